// File: doc/BRIEF.md
# Reloading Periodic Timer Bank

A bank of independent up-counting periodic timers that share one tick enable. A setup write names a timer index and a period. The block stores the negated period as that timer's reload value and presets the timer's counter near its top. Each cycle in which the tick enable is high, every counter advances by one. When a counter rolls past its maximum, it takes the reload value on the same edge and raises that timer's event flag.

Event flags stay set until software clears them through a per-flag clear input. When a new event and a clear meet in the same cycle, the event wins. Because of the preset, the first event after a setup arrives two ticks later. After that, events follow every `period` ticks. A period of zero gives the full counter range.

Top module: `periodic_timer_bank`

## Requirements
- R1: While rst_ni is low, and right after it rises, flag_o is all zero.
- R2: After a setup write to timer k, the first event on flag_o[k] arrives after exactly two ticks, whatever the period.
- R3: After the first event, timer k raises flag_o[k] every P ticks for a period P from 1 to 65535.
- R4: A period of 0 gives an interval of 65536 ticks between events.
- R5: Counters advance only in cycles with tick_i high. With tick_i low, no event occurs and no progress is made.
- R6: A set flag stays set until its bit of flag_clr_i is high in a cycle with no new event on that timer. That clear drops it on the next edge.
- R7: If a clear and a new event on the same timer fall in the same cycle, the flag remains set.
- R8: Timers are independent. A write or a clear aimed at one index leaves the count and flag of every other index unchanged.
- R9: A setup write to a running timer restarts it. Its next event comes two ticks later, and the new period applies after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Common count enable |
| wr_en_i | input | 1 | Setup write strobe |
| wr_idx_i | input | 2 | Index of the timer being set up |
| wr_period_i | input | 16 | Period in ticks (0 means 65536) |
| flag_clr_i | input | 4 | Per-timer flag clear |
| flag_o | output | 4 | Sticky event flags, bit k for timer k |

## Verification
The bench builds the block with its default parameters: four timers with 16-bit counters. Timers of this size let the bench run the full-range interval of a zero period (65536 ticks) in a single run. That run confirms the wraparound and reload path at the counter's true top value. It also measures the short periods 1, 2 and 3, where the two-tick preset and the reload interval sit next to each other.

// File: rtl/ptb_pkg.sv
package ptb_pkg;
  localparam int unsigned PTB_NUM_DEF = 4;
  localparam int unsigned PTB_CNT_W_DEF = 16;

  // one-hot of an index, gated by an enable
  function automatic logic [PTB_NUM_DEF-1:0] ptb_onehot(input logic en,
                                                        input logic [$clog2(PTB_NUM_DEF)-1:0] idx);
    logic [PTB_NUM_DEF-1:0] v;
    v = '0;
    if (en) v[idx] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/ptb_wr_decode.sv
module ptb_wr_decode #(
  parameter int unsigned NUM = 4,
  localparam int unsigned IDX_W = (NUM > 1) ? $clog2(NUM) : 1
) (
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  output logic [NUM-1:0]   load_o
);
  always_comb begin
    load_o = '0;
    for (int i = 0; i < NUM; i++) begin
      if (wr_en_i && (wr_idx_i == IDX_W'(i))) load_o[i] = 1'b1;
    end
  end
endmodule

// File: rtl/ptb_timer_slice.sv
module ptb_timer_slice #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             evt_o
);
  localparam logic [CNT_W-1:0] PRESET = {{(CNT_W-1){1'b1}}, 1'b0};

  logic [CNT_W-1:0] count_q, reload_q;
  logic             at_top;

  assign at_top = (count_q == '1);
  // setup takes priority over a tick in the same cycle
  assign evt_o  = tick_i & at_top & ~load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q  <= '0;
      reload_q <= '0;
    end else if (load_i) begin
      reload_q <= ~period_i + 1'b1;
      count_q  <= PRESET;
    end else if (tick_i) begin
      count_q  <= at_top ? reload_q : count_q + 1'b1;
    end
  end

  // R2
  preset_after_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (count_q == PRESET));
  // R5
  hold_without_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i) |=> $stable(count_q));
  // R3
  reload_on_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |=> (count_q == $past(reload_q)));
endmodule

// File: rtl/ptb_flag_reg.sv
module ptb_flag_reg #(
  parameter int unsigned NUM = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NUM-1:0] set_i,
  input  logic [NUM-1:0] clr_i,
  output logic [NUM-1:0] flag_o
);
  logic [NUM-1:0] flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= set_i | (flag_q & ~clr_i);
  end

  assign flag_o = flag_q;

  for (genvar i = 0; i < NUM; i++) begin : g_chk
    // R6
    flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q[i] && !clr_i[i]) |=> flag_q[i]);
    // R7
    set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> flag_q[i]);
    // R8
    no_spurious_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!flag_q[i] && !set_i[i]) |=> !flag_q[i]);
  end
endmodule

// File: rtl/periodic_timer_bank.sv
module periodic_timer_bank
  import ptb_pkg::*;
#(
  parameter int unsigned NUM   = PTB_NUM_DEF,
  parameter int unsigned CNT_W = PTB_CNT_W_DEF,
  localparam int unsigned IDX_W = (NUM > 1) ? $clog2(NUM) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [CNT_W-1:0] wr_period_i,
  input  logic [NUM-1:0]   flag_clr_i,
  output logic [NUM-1:0]   flag_o
);
  logic [NUM-1:0] load, evt;

  ptb_wr_decode #(.NUM(NUM)) u_dec (
    .wr_en_i (wr_en_i),
    .wr_idx_i(wr_idx_i),
    .load_o  (load)
  );

  for (genvar i = 0; i < NUM; i++) begin : g_tmr
    ptb_timer_slice #(.CNT_W(CNT_W)) u_slice (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick_i),
      .load_i  (load[i]),
      .period_i(wr_period_i),
      .evt_o   (evt[i])
    );
  end

  ptb_flag_reg #(.NUM(NUM)) u_flags (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (evt),
    .clr_i (flag_clr_i),
    .flag_o(flag_o)
  );

  // R8
  single_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(load));
  // R5
  no_evt_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |-> (evt == '0));
endmodule

// File: tb/periodic_timer_bank_tb.sv
module periodic_timer_bank_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_idx_i = '0;
  logic [15:0] wr_period_i = '0;
  logic [3:0]  flag_clr_i = '0;
  logic [3:0]  flag_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  periodic_timer_bank u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .wr_idx_i(wr_idx_i), .wr_period_i(wr_period_i), .flag_clr_i(flag_clr_i),
    .flag_o(flag_o)
  );

  // {idx, period, expected interval}
  localparam logic [34:0] VEC [6] = '{
    {2'd0, 16'd1,   17'd1},
    {2'd1, 16'd2,   17'd2},
    {2'd2, 16'd3,   17'd3},
    {2'd3, 16'd7,   17'd7},
    {2'd0, 16'd100, 17'd100},
    {2'd2, 16'd300, 17'd300}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setup(input logic [1:0] idx, input logic [15:0] p);
    @(negedge clk_i);
    tick_i = 0; wr_en_i = 1; wr_idx_i = idx; wr_period_i = p;
    flag_clr_i = 4'b0001 << idx;
    @(negedge clk_i);
    wr_en_i = 0; flag_clr_i = '0;
  endtask

  task automatic clear(input logic [3:0] m);
    @(negedge clk_i);
    tick_i = 0; flag_clr_i = m;
    @(negedge clk_i);
    flag_clr_i = '0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk_i);
    tick_i = 1;
    repeat (n) @(negedge clk_i);
    tick_i = 0;
  endtask

  // ticks until flag_o[idx] rises
  task automatic measure(input logic [1:0] idx, input int limit, output int n);
    n = 0;
    @(negedge clk_i);
    tick_i = 1;
    do begin
      @(posedge clk_i); #1;
      n++;
    end while (!flag_o[idx] && n < limit);
    @(negedge clk_i);
    tick_i = 0;
  endtask

  initial begin
    int n;
    check("R1 flags in reset", int'(flag_o), 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    check("R1 flags after reset", int'(flag_o), 0);

    for (int v = 0; v < 6; v++) begin
      logic [1:0] idx; logic [15:0] p; int exp_gap;
      idx = VEC[v][34:33]; p = VEC[v][32:17]; exp_gap = int'(VEC[v][16:0]);
      setup(idx, p);
      measure(idx, 1000, n);
      check("R2 first event", n, 2);
      clear(4'b0001 << idx);
      check("R6 clear drops flag", int'(flag_o[idx]), 0);
      measure(idx, 1000, n);
      check("R3 interval", n, exp_gap);
    end

    // R5: no progress without tick
    setup(2'd2, 16'd3);
    repeat (20) @(negedge clk_i);
    check("R5 idle no event", int'(flag_o[2]), 0);
    measure(2'd2, 100, n);
    check("R5 still two ticks after idle", n, 2);

    // R6 sticky, R7 set wins over clear
    setup(2'd0, 16'd1);
    measure(2'd0, 100, n);
    check("R2 period1 first", n, 2);
    @(negedge clk_i);
    tick_i = 1; flag_clr_i = 4'b0001;
    @(negedge clk_i);
    tick_i = 0; flag_clr_i = '0;
    check("R7 clear with event", int'(flag_o[0]), 1);
    setup(2'd1, 16'd100);
    measure(2'd1, 100, n);
    ticks(10);
    check("R6 sticky over ticks", int'(flag_o[1]), 1);
    clear(4'b0001);
    check("R6 clear without event", int'(flag_o[0]), 0);
    check("R8 other flag kept", int'(flag_o[1]), 1);

    // R8 independence, R9 restart
    setup(2'd3, 16'd50);
    measure(2'd3, 100, n);
    clear(4'b1000);
    ticks(10);
    setup(2'd0, 16'd9);
    measure(2'd3, 1000, n);
    check("R8 remaining after other write", n, 40);
    clear(4'b1000);
    ticks(10);
    setup(2'd3, 16'd50);
    measure(2'd3, 100, n);
    check("R9 restart two ticks", n, 2);
    clear(4'b1000);
    measure(2'd3, 1000, n);
    check("R9 new period", n, 50);

    // R4 period zero
    setup(2'd1, 16'd0);
    measure(2'd1, 100, n);
    check("R4 first", n, 2);
    clear(4'b0010);
    measure(2'd1, 70000, n);
    check("R4 full range", n, 65536);

    // R1 reset mid-run
    @(negedge clk_i);
    rst_ni = 0;
    #1;
    check("R1 async reset", int'(flag_o), 0);
    @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    check("R1 after re-reset", int'(flag_o), 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(CLK_PERIOD * 190000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule